// File: doc/BRIEF.md
# DDS Square Wave Generator

This block produces a signed 16-bit square wave by direct digital synthesis. A phase accumulator adds a frequency tuning word on every enabled clock cycle. The top bit of the accumulator chooses between the positive and negative full-scale levels. The output frequency is `tune_word / 2^PHASE_W` times the clock rate. A target whose period is not a whole number of clock cycles is met on average. The individual periods alternate between the two neighbouring whole counts, so the jitter stays bounded.

A clock enable gives back-pressure. While the consumer cannot accept a sample, the enable is held low. During that time the phase and the output are frozen and the valid strobe drops. The generator therefore never runs ahead of a stalled reader. A new tuning word is used on the next enabled cycle and continues from the present phase. The phase is not reset.

Top module: `dds_square_gen`

## Requirements
- R1: Whenever `sample_vld` is high, `sample_out` is either +32767 (16'h7FFF) or -32767 (16'h8001).
- R2: A synchronous reset sets the phase to zero, sets `sample_out` to 0 and sets `sample_vld` low. The first enabled sample after reset is +32767.
- R3: If `clk_en` is high at a rising edge, `sample_vld` is high in the following cycle, so one new sample appears per enabled cycle.
- R4: On each enabled edge, `sample_out` takes +32767 if the phase MSB before the edge was 0, or -32767 if it was 1. At the same edge the phase advances by `tune_word`.
- R5: If `clk_en` is low at a rising edge, the phase and `sample_out` keep their values and `sample_vld` is low in the following cycle.
- R6: A changed `tune_word` is applied at the next enabled edge. The accumulated phase is kept, not cleared.
- R7: Each output period is a whole number of enabled cycles. With a ratio of 5/32 (tuning word 671088640), every period is 6 or 7 cycles and any five consecutive periods add up to exactly 32 cycles, an average of 6.4. Disabled cycles in between do not change these counts.
- R8: The phase wraps modulo 2^PHASE_W. For example, a tuning word of all ones steps the phase from 0 to the all-ones value, so the next sample is -32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Advance enable; low freezes the generator |
| tune_word | input | PHASE_W | Phase increment per enabled cycle |
| sample_out | output | 16 | Signed square wave sample |
| sample_vld | output | 1 | High for one cycle after each enabled edge |

## Verification
Every result is due one rising edge after the edge that registered its stimulus. That edge updates the sample, the valid strobe and the phase together. The bench drives inputs at a falling edge and steps its reference model to match. It then compares the outputs at the next falling edge, which is half a cycle after the rising edge that produced them. Period lengths are counted in enabled samples taken from the observed outputs, so frozen cycles are left out in the same way the requirement leaves them out.

// File: rtl/dds_sq_pkg.sv
`timescale 1ns/1ps
package dds_sq_pkg;
  localparam int SAMPLE_W = 16;
  typedef logic signed [SAMPLE_W-1:0] sample_t;

  localparam sample_t LVL_POS = sample_t'(16'sh7FFF);
  localparam sample_t LVL_NEG = sample_t'(16'sh8001);
  localparam sample_t LVL_IDLE = '0;

  // Map the phase sign bit to a full-scale level.
  function automatic sample_t level_for(input logic neg);
    return neg ? LVL_NEG : LVL_POS;
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
`timescale 1ns/1ps
module dds_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               adv,
  input  logic [PHASE_W-1:0] step,
  output logic [PHASE_W-1:0] phase
);
  // Modulo-2^PHASE_W addition; the carry out is dropped on purpose.
  function automatic logic [PHASE_W-1:0] phase_next(
    input logic [PHASE_W-1:0] cur,
    input logic [PHASE_W-1:0] inc
  );
    return cur + inc;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase_next(phase, step);
  end
endmodule

// File: rtl/dds_level_reg.sv
`timescale 1ns/1ps
module dds_level_reg
  import dds_sq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    adv,
  input  logic    neg_sel,
  output sample_t sample_q,
  output logic    vld_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= LVL_IDLE;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= adv;
      if (adv) sample_q <= level_for(neg_sel);
    end
  end
endmodule

// File: rtl/dds_square_gen.sv
`timescale 1ns/1ps
module dds_square_gen
  import dds_sq_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clk_en,
  input  logic [PHASE_W-1:0]         tune_word,
  output logic signed [SAMPLE_W-1:0] sample_out,
  output logic                       sample_vld
);
  localparam int MSB = PHASE_W - 1;

  // Named internal events, visible to the bound checker.
  logic [PHASE_W-1:0] phase_q;
  logic               advance;
  logic               phase_neg;

  assign advance   = clk_en;
  assign phase_neg = phase_q[MSB];

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .adv   (advance),
    .step  (tune_word),
    .phase (phase_q)
  );

  dds_level_reg u_lvl (
    .clk      (clk),
    .rst      (rst),
    .adv      (advance),
    .neg_sel  (phase_neg),
    .sample_q (sample_out),
    .vld_q    (sample_vld)
  );
endmodule

// File: rtl/dds_square_gen_chk.sv
`timescale 1ns/1ps
module dds_square_gen_chk
  import dds_sq_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       clk_en,
  input logic [PHASE_W-1:0]         tune_word,
  input logic [PHASE_W-1:0]         phase_q,
  input logic signed [SAMPLE_W-1:0] sample_out,
  input logic                       sample_vld
);
  assert_level_R1: assert property (@(posedge clk) disable iff (rst)
    sample_vld |-> (sample_out == LVL_POS || sample_out == LVL_NEG));

  assert_reset_R2: assert property (@(posedge clk)
    rst |=> (phase_q == '0 && !sample_vld && sample_out == LVL_IDLE));

  assert_valid_R3: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> sample_vld);

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> phase_q == PHASE_W'($past(phase_q) + $past(tune_word)));

  assert_map_R4: assert property (@(posedge clk) disable iff (rst)
    clk_en |=> sample_out == ($past(phase_q[PHASE_W-1]) ? LVL_NEG : LVL_POS));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !clk_en |=> (!sample_vld && $stable(sample_out) && $stable(phase_q)));
endmodule

bind dds_square_gen dds_square_gen_chk #(.PHASE_W(PHASE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_en     (clk_en),
  .tune_word  (tune_word),
  .phase_q    (phase_q),
  .sample_out (sample_out),
  .sample_vld (sample_vld)
);

// File: tb/sim_dds_square_gen.sv
`timescale 1ns/1ps
module sim_dds_square_gen;
  localparam int PW = 32;
  localparam logic [PW-1:0] FTW_6P4 = 32'd671088640;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic clk_en = 1'b0;
  logic [PW-1:0] tune_word = '0;
  logic signed [15:0] sample_out;
  logic sample_vld;

  dds_square_gen #(.PHASE_W(PW)) u0 (
    .clk(clk), .rst(rst), .clk_en(clk_en), .tune_word(tune_word),
    .sample_out(sample_out), .sample_vld(sample_vld)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [PW-1:0] m_acc;
  logic signed [15:0] m_smp;
  logic m_vld;

  function automatic logic signed [15:0] exp_level(input logic [PW-1:0] acc);
    return acc[PW-1] ? -16'sd32767 : 16'sd32767;
  endfunction

  task automatic chk_int(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit en, input logic [PW-1:0] ftw, input string tag);
    clk_en = en;
    tune_word = ftw;
    if (en) begin
      m_smp = exp_level(m_acc);
      m_acc = m_acc + ftw;
    end
    m_vld = en;
    @(negedge clk);
    chk_int({tag, " sample"}, int'(sample_out), int'(m_smp));
    chk_int({tag, " valid"}, int'(sample_vld), int'(m_vld));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    clk_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_acc = '0;
    m_smp = '0;
    m_vld = 1'b0;
    chk_int("R2 reset sample", int'(sample_out), 0);
    chk_int("R2 reset valid", int'(sample_vld), 0);
  endtask

  task automatic run_jitter();
    int cnt = 0;
    int nper = 0;
    bit seen = 1'b0;
    logic signed [15:0] prev = 16'sd32767;
    int last5 [5] = '{0, 0, 0, 0, 0};
    do_reset();
    for (int i = 0; i < 400; i++) begin
      if (i % 9 == 4) begin
        step(1'b0, FTW_6P4, "R7 stall");
        continue;
      end
      step(1'b1, FTW_6P4, "R7 run");
      cnt++;
      if (prev == -16'sd32767 && sample_out == 16'sd32767) begin
        if (seen) begin
          chk_int("R7 period is 6 or 7", int'(cnt == 6 || cnt == 7), 1);
          last5[nper % 5] = cnt;
          nper++;
          if (nper >= 5)
            chk_int("R7 five periods span", last5[0] + last5[1] + last5[2] + last5[3] + last5[4], 32);
        end
        seen = 1'b1;
        cnt = 0;
      end
      prev = sample_out;
    end
    chk_int("R7 enough periods seen", int'(nper >= 20), 1);
  endtask

  initial begin
    int unsigned seed_dummy;
    logic [PW-1:0] ftw;
    seed_dummy = $urandom(32'd20240611);
    @(negedge clk);
    do_reset();
    step(1'b1, FTW_6P4, "R2 first sample");
    for (int i = 0; i < 10; i++) step(1'b1, FTW_6P4, "R4 run");
    for (int i = 0; i < 4; i++) step(1'b0, $urandom, "R5 frozen");
    step(1'b1, FTW_6P4, "R3 resume");
    // Tuning change mid-stream keeps phase.
    step(1'b1, 32'h4000_0000, "R6 retune");
    for (int i = 0; i < 6; i++) step(1'b1, 32'h4000_0000, "R6 new rate");
    // Wrap below zero.
    do_reset();
    step(1'b1, 32'hFFFF_FFFF, "R8 wrap first");
    step(1'b1, 32'hFFFF_FFFF, "R8 wrap negative");
    step(1'b1, 32'h8000_0001, "R8 wrap half");
    step(1'b1, 32'h0000_0000, "R8 zero step");
    run_jitter();
    // Constrained random mix.
    do_reset();
    ftw = $urandom;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 31) == 0) ftw = $urandom;
      step($urandom_range(0, 3) != 0, ftw, "R4 random");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule